// File: doc/BRIEF.md
# Power Management Control and Status Register

This block is an 8-bit control and status register on a simple register bus. The bus gives it a decoded select, a write strobe, write data and read data. The register holds four settings and one flag:

- a low-voltage detect trip-point select;
- a low-voltage warning trip-point select;
- a stop-mode select;
- a flag that records a return from the partial-power-down stop mode, which software clears by writing 1 to an acknowledge bit.

The block only stores, protects and reports these bits. The voltage comparators, the stop sequencing and the clock gating live elsewhere and read the bits from dedicated outputs.

Two of the selects are write-once, but each is reopened by a different reset class. The detect select is reopened only by a power-on reset. The stop-mode select is reopened by any reset. Both trip-point selects keep their values through a low-voltage reset or any other non-power-on reset. The three reset inputs are synchronous and active-low. Power-on reset wins whenever it is asserted. A one-cycle pulse input marks recovery from the deep stop mode.

Top module: `pm_ctl_reg`

## Requirements
- R1: While the power-on reset is asserted at a clock edge, every register bit clears to 0, so `rdata` reads 0x00 afterwards.
- R2: A low-voltage reset or another non-power-on reset keeps bits 5 and 4 and clears bits 3 and 0.
- R3: Bit 5 (detect trip select) takes the first write after a power-on reset and ignores all later writes. A non-power-on reset does not reopen it.
- R4: Bit 0 (stop-mode select, 1 = partial power down) takes the first write after any reset and ignores later writes.
- R5: A write-once bit locks on the first write to the register, even when that write leaves the bit's value unchanged.
- R6: Bit 4 (warning trip select) follows every write to the register.
- R7: A recovery pulse sets bit 3 at the next clock edge. Writes to bit 3 have no effect on it.
- R8: A write with bit 2 = 1 clears bit 3. A write with bit 2 = 0 leaves bit 3 unchanged. Bit 2 always reads 0.
- R9: When a recovery pulse and a write with bit 2 = 1 fall in the same cycle, bit 3 ends up set.
- R10: Bits 7, 6 and 1 always read 0, whatever value is written to them.
- R11: When the power-on reset is asserted together with another reset, the power-on behaviour applies: all bits clear and both locks reopen.
- R12: A write strobe without select changes no bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| por_rst_n | input | 1 | Power-on reset, synchronous, active-low |
| lv_rst_n | input | 1 | Low-voltage reset, synchronous, active-low |
| oth_rst_n | input | 1 | Any other reset, synchronous, active-low |
| sel_i | input | 1 | Decoded register select |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from stored state |
| deep_wake_i | input | 1 | One-cycle pulse: recovery from the partial-power-down stop mode |
| lvd_sel_o | output | 1 | Detect trip select (bit 5) |
| lvw_sel_o | output | 1 | Warning trip select (bit 4) |
| stop_deep_o | output | 1 | Stop-mode select (bit 0) |

## Verification
A write, an acknowledge, a recovery pulse or a reset acts at the first rising edge that samples it. Read data is combinational from the stored bits, so each result can be read in the half cycle after that edge. The bench changes inputs on falling edges and holds them for exactly one rising edge. It samples `rdata` and the select outputs at the following falling edge, which is one register stage after the stimulus and before the next edge can disturb it. The combined pulse-and-acknowledge case applies both inputs in the same window to show the ordering.

// File: rtl/pm_reg_pkg.sv
// Package: shared field positions and reset-class type for the power
// management register. Assumes an 8-bit register; the positions are
// decoded by software and must not move.
package pm_reg_pkg;
    localparam int REG_W    = 8;
    localparam int LVD_BIT  = 5;
    localparam int LVW_BIT  = 4;
    localparam int FLAG_BIT = 3;
    localparam int ACK_BIT  = 2;
    localparam int STOP_BIT = 0;

    // Reset classes seen by every storage cell in one cycle.
    typedef struct packed {
        logic cold;   // power-on reset asserted
        logic warm;   // low-voltage or other reset asserted
    } rst_cls_t;
endpackage

// File: rtl/pm_ctl_bit.sv
// Module: one control bit with an optional write-once lock.
// WRITE_ONCE = 1 : the first write sets the lock; later writes are ignored.
// KEEP_WARM  = 1 : value and lock survive a warm reset; only cold clears them.
// Assumes rst.cold dominates rst.warm and that wr_i is already decoded.
module pm_ctl_bit
    import pm_reg_pkg::*;
#(
    parameter bit WRITE_ONCE = 1'b1,
    parameter bit KEEP_WARM  = 1'b0
) (
    input  logic     clk,
    input  rst_cls_t rst,
    input  logic     wr_i,
    input  logic     d_i,
    output logic     q_o
);
    logic val_q;
    logic locked;

    generate
        if (WRITE_ONCE) begin : g_once
            logic lock_q;

            // Purpose: track whether the one allowed write has happened.
            always_ff @(posedge clk) begin
                if (rst.cold)
                    lock_q <= 1'b0;
                else if (rst.warm && !KEEP_WARM)
                    lock_q <= 1'b0;
                else if (!rst.warm && wr_i)
                    lock_q <= 1'b1;
            end
            assign locked = lock_q;

            // Locked bit ignores writes (R3, R4, R5)
            assert_locked_hold_R3: assert property (@(posedge clk)
                disable iff (rst.cold || rst.warm)
                (lock_q && wr_i) |=> $stable(val_q));
        end else begin : g_free
            assign locked = 1'b0;
        end

        if (KEEP_WARM) begin : g_keep
            // Warm reset leaves the value untouched (R2)
            assert_warm_keep_R2: assert property (@(posedge clk)
                (rst.warm && !rst.cold) |=> (val_q == $past(val_q)));
        end
    endgenerate

    // Purpose: update the stored value on reset or an accepted write.
    always_ff @(posedge clk) begin
        if (rst.cold)
            val_q <= 1'b0;
        else if (rst.warm) begin
            if (!KEEP_WARM)
                val_q <= 1'b0;
        end else if (wr_i && !locked)
            val_q <= d_i;
    end

    assign q_o = val_q;

    // Cold reset clears the value (R1)
    assert_cold_zero_R1: assert property (@(posedge clk)
        rst.cold |=> (val_q == 1'b0));
endmodule

// File: rtl/pm_wake_flag.sv
// Module: sticky recovery flag. A hardware pulse sets it and a software
// acknowledge clears it. The pulse wins over a same-cycle acknowledge, so
// no event is lost. Any reset clears the flag.
module pm_wake_flag
    import pm_reg_pkg::*;
(
    input  logic     clk,
    input  rst_cls_t rst,
    input  logic     set_i,
    input  logic     ack_i,
    output logic     flag_o
);
    logic flag_q;

    // Purpose: set on the pulse, clear on acknowledge, clear on any reset.
    always_ff @(posedge clk) begin
        if (rst.cold || rst.warm)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (ack_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // A pulse is always recorded, even with a same-cycle ack (R7, R9)
    assert_pulse_sets_R9: assert property (@(posedge clk)
        disable iff (rst.cold || rst.warm)
        set_i |=> flag_q);

    // Acknowledge without a pulse clears the flag (R8)
    assert_ack_clears_R8: assert property (@(posedge clk)
        disable iff (rst.cold || rst.warm)
        (ack_i && !set_i) |=> !flag_q);

    // Without pulse or ack, the flag holds (R8, R12)
    assert_flag_hold_R8: assert property (@(posedge clk)
        disable iff (rst.cold || rst.warm)
        (!ack_i && !set_i) |=> $stable(flag_q));
endmodule

// File: rtl/pm_ctl_reg.sv
// Module: top of the power management control/status register.
// It decodes bus writes, classifies the three synchronous active-low
// resets and assembles the read word. Assumes sel_i is already
// address-decoded and deep_wake_i is a single-cycle pulse.
module pm_ctl_reg
    import pm_reg_pkg::*;
(
    input  logic             clk,
    input  logic             por_rst_n,
    input  logic             lv_rst_n,
    input  logic             oth_rst_n,
    input  logic             sel_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    input  logic             deep_wake_i,
    output logic             lvd_sel_o,
    output logic             lvw_sel_o,
    output logic             stop_deep_o
);
    rst_cls_t rst;
    logic     wr;
    logic     ack;
    logic     lvd_q;
    logic     lvw_q;
    logic     stop_q;
    logic     flag_q;

    // Purpose: classify reset; power-on dominates the other two.
    always_comb begin
        rst.cold = !por_rst_n;
        rst.warm = por_rst_n && (!lv_rst_n || !oth_rst_n);
    end

    assign wr  = sel_i && wr_en_i;
    assign ack = wr && wdata_i[ACK_BIT];

    pm_ctl_bit #(.WRITE_ONCE(1'b1), .KEEP_WARM(1'b1)) u_lvd (
        .clk(clk), .rst(rst), .wr_i(wr), .d_i(wdata_i[LVD_BIT]), .q_o(lvd_q)
    );

    pm_ctl_bit #(.WRITE_ONCE(1'b0), .KEEP_WARM(1'b1)) u_lvw (
        .clk(clk), .rst(rst), .wr_i(wr), .d_i(wdata_i[LVW_BIT]), .q_o(lvw_q)
    );

    pm_ctl_bit #(.WRITE_ONCE(1'b1), .KEEP_WARM(1'b0)) u_stop (
        .clk(clk), .rst(rst), .wr_i(wr), .d_i(wdata_i[STOP_BIT]), .q_o(stop_q)
    );

    pm_wake_flag u_flag (
        .clk(clk), .rst(rst), .set_i(deep_wake_i), .ack_i(ack), .flag_o(flag_q)
    );

    // Purpose: assemble the read word; unimplemented and ack bits read 0.
    always_comb begin
        rdata_o           = '0;
        rdata_o[LVD_BIT]  = lvd_q;
        rdata_o[LVW_BIT]  = lvw_q;
        rdata_o[FLAG_BIT] = flag_q;
        rdata_o[STOP_BIT] = stop_q;
    end

    assign lvd_sel_o   = lvd_q;
    assign lvw_sel_o   = lvw_q;
    assign stop_deep_o = stop_q;

    // Power-on reset leaves the whole register clear (R1, R11)
    assert_por_clear_R11: assert property (@(posedge clk)
        !por_rst_n |=> (rdata_o == '0));

    // Warm reset clears the flag and stop select (R2)
    assert_warm_clear_R2: assert property (@(posedge clk)
        (por_rst_n && !lv_rst_n) |=> (!flag_q && !stop_q));

    // Without a select, the warning select holds (R12)
    assert_nosel_hold_R12: assert property (@(posedge clk)
        disable iff (!por_rst_n || !lv_rst_n || !oth_rst_n)
        !sel_i |=> $stable(lvw_q));
endmodule

// File: tb/pm_ctl_reg_bench.sv
module pm_ctl_reg_bench;
    logic       clk = 1'b0;
    logic       por_rst_n = 1'b0;
    logic       lv_rst_n  = 1'b0;
    logic       oth_rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       we  = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       wake = 1'b0;
    logic [7:0] rdata;
    logic       lvd_sel, lvw_sel, stop_deep;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pm_ctl_reg u_pm_ctl_reg (
        .clk(clk), .por_rst_n(por_rst_n), .lv_rst_n(lv_rst_n),
        .oth_rst_n(oth_rst_n), .sel_i(sel), .wr_en_i(we), .wdata_i(wdata),
        .rdata_o(rdata), .deep_wake_i(wake), .lvd_sel_o(lvd_sel),
        .lvw_sel_o(lvw_sel), .stop_deep_o(stop_deep)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // One write cycle; the result is visible at the returning falling edge.
    task automatic bus_write(input logic [7:0] d, input logic s = 1'b1, input logic pulse = 1'b0);
        @(negedge clk);
        sel = s; we = 1'b1; wdata = d; wake = pulse;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; wdata = 8'h00; wake = 1'b0;
    endtask

    task automatic wake_pulse();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
    endtask

    task automatic apply_reset(input logic por, input logic lv, input logic oth);
        @(negedge clk);
        por_rst_n = ~por; lv_rst_n = ~lv; oth_rst_n = ~oth;
        @(negedge clk);
        @(negedge clk);
        por_rst_n = 1'b1; lv_rst_n = 1'b1; oth_rst_n = 1'b1;
    endtask

    task automatic t_power_on();
        apply_reset(1'b1, 1'b0, 1'b0);
        check("R1 reset state", rdata, 8'h00);
    endtask

    task automatic t_write_rules();
        bus_write(8'h31);
        check("R3 R4 R6 first write", rdata, 8'h31);
        check("R3 lvd output", {7'b0, lvd_sel}, 8'h01);
        bus_write(8'h00);
        check("R3 R4 locked, R6 free", rdata, 8'h21);
        check("R6 lvw output", {7'b0, lvw_sel}, 8'h00);
        bus_write(8'hD2);
        check("R10 reserved bits read 0", rdata, 8'h31);
        check("R4 stop output", {7'b0, stop_deep}, 8'h01);
    endtask

    task automatic t_warm_resets();
        apply_reset(1'b0, 1'b1, 1'b0);
        check("R2 low-voltage reset keeps 5,4", rdata, 8'h30);
        bus_write(8'h01);
        check("R3 stays locked, R4 reopened", rdata, 8'h21);
        apply_reset(1'b0, 1'b0, 1'b1);
        check("R2 other reset", rdata, 8'h20);
        bus_write(8'h10);
        check("R6 after other reset", rdata, 8'h30);
    endtask

    task automatic t_flag();
        wake_pulse();
        check("R7 pulse sets flag", rdata, 8'h38);
        bus_write(8'h30);
        check("R8 ack=0 no effect", rdata, 8'h38);
        bus_write(8'h34);
        check("R8 ack clears, bit2 reads 0", rdata, 8'h30);
        bus_write(8'h34, 1'b1, 1'b1);
        check("R9 pulse beats ack", rdata, 8'h38);
        bus_write(8'h34);
        bus_write(8'h38);
        check("R7 flag not writable", rdata, 8'h30);
        wake_pulse();
        apply_reset(1'b0, 1'b1, 1'b0);
        check("R2 warm reset clears flag", rdata, 8'h30);
    endtask

    task automatic t_no_select();
        bus_write(8'h00, 1'b0);
        check("R12 write without select", rdata, 8'h30);
    endtask

    task automatic t_same_value_lock();
        apply_reset(1'b1, 1'b0, 1'b0);
        bus_write(8'h00);
        bus_write(8'h31);
        check("R5 same-value write locks", rdata, 8'h10);
    endtask

    task automatic t_priority();
        apply_reset(1'b1, 1'b0, 1'b1);
        check("R11 combined reset clears", rdata, 8'h00);
        bus_write(8'h21);
        check("R11 locks reopened", rdata, 8'h21);
    endtask

    initial begin
        t_power_on();
        t_write_rules();
        t_warm_resets();
        t_flag();
        t_no_select();
        t_same_value_lock();
        t_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule